// File: doc/BRIEF.md
# Indexed Palette Write Port

This block is a colour lookup table loaded by a host through a narrow indirect register interface. The host first writes an entry number into a shared pointer register, then pushes the red, green and blue components of that entry one after another through a single colour data register. The new colour is written into the table only when the blue component arrives, so the table never holds a partly updated entry. The pointer then moves to the next entry by itself, which lets the host load a run of consecutive entries after a single pointer write.

The pixel side supplies an 8-bit pixel index on every cycle and gets back a 24-bit colour one clock later. The same pointer register also selects a small bank of indirect control bytes, numbered 4 to 7. Byte 4 is a read plane mask that is ANDed with the pixel index before the lookup. Byte 6 is an overlay control byte. Bytes 5 and 7 are spare. All bank bytes are brought out on a port.

Component sequencing is held in a state machine with three states. PH_RED is the reset state and waits for the red component. PH_GREEN waits for green. PH_BLUE waits for blue. The transitions are:
- red write: PH_RED to PH_GREEN.
- green write: PH_GREEN to PH_BLUE.
- blue write: PH_BLUE to PH_RED. This transition also commits the entry and advances the pointer.
- pointer write: any state to PH_RED.

Top module: `pal_port`

## Requirements
- R1: After reset, every table entry is 0x000000, `pix_rgb` is 0 and the pointer is 0. The control bank resets to byte 4 = 0xFF, byte 5 = 0x00, byte 6 = 0x73 and byte 7 = 0x00, so `ctl_bank` = 0x007300FF.
- R2: A write with `host_sel` = 0 loads the pointer from bits 31:24 of `host_wdata` and returns the sequencer to PH_RED.
- R3: After a pointer write, three writes with `host_sel` = 1 supply red, then green, then blue for the pointed entry, each component taken from bits 31:24. A lookup of that entry returns red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: Until the blue component is written, a lookup of the entry being loaded returns its previous contents.
- R5: After the blue write the pointer advances by one modulo 256, so entry 0xFF is followed by entry 0x00.
- R6: A pointer write in the middle of a colour sequence discards the components already staged, and the next colour write is taken as red.
- R7: A write with `host_sel` = 2 while the pointer holds 4, 5, 6 or 7 loads bits 31:24 into that bank byte. Bank byte n appears on `ctl_bank[8*(n-4)+7 : 8*(n-4)]`.
- R8: A write with `host_sel` = 2 while the pointer is outside 4 to 7 changes no bank byte.
- R9: A write with `host_sel` = 2 moves neither the pointer nor the component sequence.
- R10: `pix_rgb` shows the entry at (`pix_idx` AND bank byte 4), one clock after `pix_idx` is presented.
- R11: Bits 23:0 of every host write are ignored. A write with `host_sel` = 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one write per cycle |
| host_sel | input | 2 | Register select: 0 pointer, 1 colour data, 2 control data, 3 reserved |
| host_wdata | input | 32 | Host write data; only bits 31:24 are used |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Registered colour for the masked pixel index |
| ctl_bank | output | 32 | Control bytes 4 (low byte) to 7 (high byte) |

## Verification
The bench builds the block with its default parameters: 8-bit index and components, a 32-bit host word, and a four-byte bank starting at register 4. With these values the full 256-entry table can be addressed, so the pointer wrap from 0xFF to 0x00 is reached directly. The plane mask can cut the index down to 4 bits, which makes an alias between entries visible at the lookup port. The bank boundaries can also be probed at pointer values 3 and 8.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        SEL_PTR   = 2'd0,
        SEL_COLOR = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_RSVD  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    // Reset value of control bank byte k (bank starts at register 4).
    function automatic logic [7:0] bank_init(input int k);
        case (k)
            0:       return 8'hFF;
            2:       return 8'h73;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  reg_sel_e              wr_sel,
    input  logic [BUS_W-1:0]      wr_data,
    output logic [IDX_W-1:0]      cur_idx,
    output logic                  commit,
    output logic [3*COMP_W-1:0]   commit_rgb
);

    logic [COMP_W-1:0] comp_field;
    logic [IDX_W-1:0]  ptr_field;
    logic              ptr_wr, color_wr, ctrl_wr;
    phase_e            state_q, state_d;
    logic [COMP_W-1:0] red_q, green_q;
    logic [IDX_W-1:0]  idx_q;

    assign comp_field = wr_data[BUS_W-1 -: COMP_W];
    assign ptr_field  = wr_data[BUS_W-1 -: IDX_W];
    assign ptr_wr     = wr_en && (wr_sel == SEL_PTR);
    assign color_wr   = wr_en && (wr_sel == SEL_COLOR);
    assign ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ptr_wr) begin
            state_d = PH_RED;
        end else if (color_wr) begin
            unique case (state_q)
                PH_RED:   state_d = PH_GREEN;
                PH_GREEN: state_d = PH_BLUE;
                PH_BLUE:  state_d = PH_RED;
                default:  state_d = PH_RED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_RED;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        commit     = color_wr && (state_q == PH_BLUE);
        commit_rgb = {red_q, green_q, comp_field};
        cur_idx    = idx_q;
    end

    // Pointer and staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            red_q   <= '0;
            green_q <= '0;
        end else if (ptr_wr) begin
            idx_q <= ptr_field;
        end else if (color_wr) begin
            unique case (state_q)
                PH_RED:   red_q   <= comp_field;
                PH_GREEN: green_q <= comp_field;
                PH_BLUE:  idx_q   <= idx_q + IDX_W'(1);
                default:  ;
            endcase
        end
    end

    p_addr_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (state_q == PH_RED));

    p_index_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (idx_q == $past(idx_q) + IDX_W'(1)));

    p_ctl_keeps_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ($stable(idx_q) && $stable(state_q)));

    p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != phase_e'(2'd3));

endmodule

// File: rtl/pal_table.sv
module pal_table #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [3*COMP_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [IDX_W-1:0]    rd_mask,
    output logic [3*COMP_W-1:0] rd_rgb
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int RGB_W = 3 * COMP_W;

    logic [RGB_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] eff_idx;

    assign eff_idx = rd_idx & rd_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_rgb <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_rgb;
            rd_rgb <= mem[eff_idx];
        end
    end

    p_no_write_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> !wr_en);

endmodule

// File: rtl/pal_ctl_bank.sv
module pal_ctl_bank
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int FIRST  = 4,
    parameter int COUNT  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        sel_idx,
    input  logic [COMP_W-1:0]       wr_val,
    output logic [COUNT*COMP_W-1:0] bank_o
);

    logic [COUNT-1:0] hit;

    for (genvar k = 0; k < COUNT; k++) begin : g_byte
        logic [COMP_W-1:0] val_q;
        assign hit[k] = wr_en && (sel_idx == IDX_W'(FIRST + k));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      val_q <= COMP_W'(bank_init(k));
            else if (hit[k]) val_q <= wr_val;
        end
        assign bank_o[k*COMP_W +: COMP_W] = val_q;
    end

    p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_o));

endmodule

// File: rtl/pal_port.sv
module pal_port
    import pal_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int COMP_W   = 8,
    parameter int BUS_W    = 32,
    parameter int CTL_BASE = 4,
    parameter int CTL_CNT  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr,
    input  logic [1:0]                host_sel,
    input  logic [BUS_W-1:0]          host_wdata,
    input  logic [IDX_W-1:0]          pix_idx,
    output logic [3*COMP_W-1:0]       pix_rgb,
    output logic [CTL_CNT*COMP_W-1:0] ctl_bank
);

    localparam int RGB_W = 3 * COMP_W;

    reg_sel_e           sel;
    logic [IDX_W-1:0]   cur_idx;
    logic               commit;
    logic [RGB_W-1:0]   commit_rgb;
    logic               ctrl_wr;
    logic [IDX_W-1:0]   plane_mask;

    assign sel        = reg_sel_e'(host_sel);
    assign ctrl_wr    = host_wr && (sel == SEL_CTRL);
    assign plane_mask = IDX_W'(ctl_bank[COMP_W-1:0]);

    pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr),
        .wr_sel     (sel),
        .wr_data    (host_wdata),
        .cur_idx    (cur_idx),
        .commit     (commit),
        .commit_rgb (commit_rgb)
    );

    pal_table #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (cur_idx),
        .wr_rgb  (commit_rgb),
        .rd_idx  (pix_idx),
        .rd_mask (plane_mask),
        .rd_rgb  (pix_rgb)
    );

    pal_ctl_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W),
                   .FIRST(CTL_BASE), .COUNT(CTL_CNT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .sel_idx (cur_idx),
        .wr_val  (host_wdata[BUS_W-1 -: COMP_W]),
        .bank_o  (ctl_bank)
    );

    p_commit_from_color_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (host_wr && sel == SEL_COLOR));

    p_rsvd_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel == SEL_RSVD) |=> ($stable(cur_idx) && $stable(ctl_bank)));

endmodule

// File: tb/tb_pal_port.sv
module tb_pal_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [31:0] ctl_bank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pal_port dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .ctl_bank(ctl_bank)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v, input logic [23:0] junk);
        @(negedge clk);
        host_wr = 1'b1; host_sel = s; host_wdata = {v, junk};
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic color(input logic [23:0] rgb);
        wr(2'd1, rgb[23:16], 24'h5A5A5A);
        wr(2'd1, rgb[15:8],  24'hA5A5A5);
        wr(2'd1, rgb[7:0],   24'hFFFFFF);
    endtask

    task automatic look(input logic [7:0] idx, output logic [23:0] rgb);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        rgb = pix_rgb;
    endtask

    task automatic t_reset;
        logic [23:0] v;
        chk("R1 pix_rgb", {8'h0, pix_rgb}, 32'h0);
        chk("R1 ctl_bank", ctl_bank, 32'h007300FF);
        look(8'h00, v); chk("R1 entry 00", {8'h0, v}, 32'h0);
        look(8'hFF, v); chk("R1 entry FF", {8'h0, v}, 32'h0);
    endtask

    task automatic t_basic;
        logic [23:0] v;
        wr(2'd0, 8'h10, 24'hFFFFFF);
        color(24'h123456);
        look(8'h10, v); chk("R2 R3 R11 entry 10", {8'h0, v}, 32'h123456);
    endtask

    task automatic t_partial;
        logic [23:0] v;
        wr(2'd0, 8'h20, 24'h0);
        wr(2'd1, 8'hAA, 24'h0);
        wr(2'd1, 8'hBB, 24'h0);
        look(8'h20, v); chk("R4 before blue", {8'h0, v}, 32'h0);
        wr(2'd1, 8'hCC, 24'h0);
        look(8'h20, v); chk("R4 after blue", {8'h0, v}, 32'hAABBCC);
    endtask

    task automatic t_stream_wrap;
        logic [23:0] v;
        wr(2'd0, 8'hFE, 24'h0);
        color(24'h0A0B0C);
        color(24'h0D0E0F);
        color(24'h101112);
        look(8'hFE, v); chk("R5 entry FE", {8'h0, v}, 32'h0A0B0C);
        look(8'hFF, v); chk("R5 entry FF", {8'h0, v}, 32'h0D0E0F);
        look(8'h00, v); chk("R5 wrap entry 00", {8'h0, v}, 32'h101112);
    endtask

    task automatic t_abandon;
        logic [23:0] v;
        wr(2'd0, 8'h30, 24'h0);
        wr(2'd1, 8'h11, 24'h0);
        wr(2'd1, 8'h22, 24'h0);
        wr(2'd0, 8'h30, 24'h0);
        color(24'h445566);
        look(8'h30, v); chk("R6 restart", {8'h0, v}, 32'h445566);
        look(8'h31, v); chk("R6 next untouched", {8'h0, v}, 32'h0);
    endtask

    task automatic t_ctl;
        wr(2'd0, 8'h05, 24'h0); wr(2'd2, 8'h5A, 24'hFFFFFF);
        chk("R7 byte5", ctl_bank, 32'h00735AFF);
        wr(2'd0, 8'h07, 24'h0); wr(2'd2, 8'hC3, 24'h0);
        chk("R7 byte7", ctl_bank, 32'hC3735AFF);
        wr(2'd0, 8'h06, 24'h0); wr(2'd2, 8'h01, 24'h0);
        chk("R7 byte6", ctl_bank, 32'hC3015AFF);
    endtask

    task automatic t_ctl_ignored;
        wr(2'd0, 8'h03, 24'h0); wr(2'd2, 8'h99, 24'h0);
        chk("R8 ptr 03", ctl_bank, 32'hC3015AFF);
        wr(2'd0, 8'h08, 24'h0); wr(2'd2, 8'h99, 24'h0);
        chk("R8 ptr 08", ctl_bank, 32'hC3015AFF);
    endtask

    task automatic t_ctl_no_seq;
        logic [23:0] v;
        wr(2'd0, 8'h40, 24'h0);
        wr(2'd1, 8'h01, 24'h0);
        wr(2'd2, 8'h77, 24'h0);
        wr(2'd1, 8'h02, 24'h0);
        wr(2'd1, 8'h03, 24'h0);
        color(24'h070809);
        look(8'h40, v); chk("R9 entry 40", {8'h0, v}, 32'h010203);
        look(8'h41, v); chk("R9 entry 41", {8'h0, v}, 32'h070809);
        chk("R9 bank", ctl_bank, 32'hC3015AFF);
    endtask

    task automatic t_rsvd;
        logic [23:0] v;
        wr(2'd0, 8'h50, 24'h0);
        wr(2'd1, 8'h21, 24'h0);
        wr(2'd3, 8'h99, 24'h0);
        wr(2'd1, 8'h22, 24'h0);
        wr(2'd3, 8'h04, 24'h0);
        wr(2'd1, 8'h23, 24'h0);
        look(8'h50, v); chk("R11 sel3 inert", {8'h0, v}, 32'h212223);
        chk("R11 bank", ctl_bank, 32'hC3015AFF);
    endtask

    task automatic t_mask_latency;
        logic [23:0] v;
        wr(2'd0, 8'h0F, 24'h0);
        color(24'hABCDEF);
        wr(2'd0, 8'h04, 24'h0); wr(2'd2, 8'h0F, 24'h0);
        look(8'h1F, v); chk("R10 mask 1F->0F", {8'h0, v}, 32'hABCDEF);
        look(8'h10, v); chk("R10 mask 10->00", {8'h0, v}, 32'h101112);
        wr(2'd2, 8'hFF, 24'h0);
        look(8'h00, v);
        @(negedge clk);
        pix_idx = 8'h10;
        #1 chk("R10 no early change", {8'h0, pix_rgb}, 32'h101112);
        @(negedge clk);
        chk("R10 one cycle", {8'h0, pix_rgb}, 32'h123456);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_partial();
        t_stream_wrap();
        t_abandon();
        t_ctl();
        t_ctl_ignored();
        t_ctl_no_seq();
        t_rsvd();
        t_mask_latency();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule